// File: doc/BRIEF.md
# Receive Converter Output Multiplexer

This block prepares the receive-side converter results for the output pins. Two matched 8-bit converters deliver in-phase (I) and quadrature (Q) samples with a strobe. The block time-multiplexes each I/Q pair onto a single 4-bit bus, one nibble per master-clock cycle. A frame flag marks where each pair begins.

A third converter delivers 12-bit IF samples with its own strobe. These go out unmultiplexed on a separate 12-bit bus that updates at half the master-clock rate, with a one-cycle data-valid on each update.

Both converter inputs are captured into holding registers whenever their strobe is high. Each output path takes the latest captured value only at its own update point. A sample pair is therefore never torn across two different conversions, and a 12-bit word is never replaced between updates.

Top module: `rxconv_out_mux`

## Requirements
- R1: While reset is asserted, and after its release until the first rising clock edge, the nibble bus, frame flag, 12-bit bus and data-valid are all zero.
- R2: Each sequence presents four nibbles on successive cycles, in this order: I bits 7..4, I bits 3..0, Q bits 7..4, Q bits 3..0.
- R3: The frame flag is high for exactly one cycle in every four, always together with the I bits 7..4 nibble. The first flagged cycle follows the first clock edge after reset release.
- R4: A pair strobed while a sequence is in progress does not alter that sequence's remaining nibbles. It appears from the next flagged cycle.
- R5: A pair strobed on the clock edge that places the Q bits 3..0 nibble on the bus is the one sent in the immediately following sequence.
- R6: When several pairs are strobed within one sequence, only the last of them is sent in the next sequence.
- R7: With no new strobe, the most recently captured pair is sent again in every sequence. Before any strobe, that pair is zero.
- R8: The 12-bit bus updates on every second clock edge, starting with the second edge after reset release. Data-valid is high for exactly the one cycle after each update edge.
- R9: On an update edge, the 12-bit bus takes the most recent sample strobed at or before that edge. A sample strobed on the update edge itself passes straight through.
- R10: Between update edges the 12-bit bus holds its value, even when a new sample is strobed. Without any strobe, each update repeats the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one nibble per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iq_stb | input | 1 | Strobe: new I/Q pair present on i_samp/q_samp |
| i_samp | input | 8 | In-phase converter sample |
| q_samp | input | 8 | Quadrature converter sample |
| if_stb | input | 1 | Strobe: new IF sample present on if_samp |
| if_samp | input | 12 | IF converter sample |
| nib_out | output | 4 | Multiplexed I/Q nibble bus |
| nib_sof | output | 1 | High with the first nibble (I bits 7..4) of each sequence |
| if_out | output | 12 | Half-rate IF sample bus |
| if_dv | output | 1 | One-cycle data-valid for each IF update |

## Verification
Two events land on the same clock edge every fourth cycle: the nibble sequence loads its next pair, and the IF port makes an update. The bench provokes this alignment by strobing both converters on that edge, with fresh values on each. It then requires both strobed values to pass through at once, the pair from the next flagged cycle and the IF word in the following data-valid cycle. A behavioural model compares the nibble bus, flag, IF bus and valid after every clock edge, so a strobe that is lost, delayed or taken one sequence early shows up as a mismatch.

// File: rtl/rxmux_pkg.sv
package rxmux_pkg;

  localparam int unsigned DEF_SAMP_W = 8;
  localparam int unsigned DEF_NIB_W  = 4;
  localparam int unsigned DEF_IF_W   = 12;
  localparam int unsigned DEF_IF_DIV = 2;

  // width of a counter that runs 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

  // lowest bit of the nibble sent in a given slot; slot 0 is the top of the pair
  function automatic int unsigned slot_lsb(input int unsigned slot,
                                           input int unsigned slots,
                                           input int unsigned nib_w);
    return (slots - 1 - slot) * nib_w;
  endfunction

endpackage

// File: rtl/rxmux_pair_stage.sv
module rxmux_pair_stage #(
  parameter int unsigned SAMP_W = rxmux_pkg::DEF_SAMP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stb,
  input  logic [SAMP_W-1:0]     i_in,
  input  logic [SAMP_W-1:0]     q_in,
  output logic [2*SAMP_W-1:0]   pair_next
);

  logic [2*SAMP_W-1:0] pend_q;

  // latest pair, with a strobe in this cycle taking priority over the held one
  assign pair_next = stb ? {i_in, q_in} : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pair_next;
  end

endmodule

// File: rtl/rxmux_nib_seq.sv
module rxmux_nib_seq #(
  parameter int unsigned SAMP_W = rxmux_pkg::DEF_SAMP_W,
  parameter int unsigned NIB_W  = rxmux_pkg::DEF_NIB_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*SAMP_W-1:0]   pair_next,
  output logic [NIB_W-1:0]      nib_out,
  output logic                  nib_sof,
  output logic [2*SAMP_W-1:0]   act_pair
);

  localparam int unsigned SLOTS = 2 * (SAMP_W / NIB_W);
  localparam int unsigned PH_W  = rxmux_pkg::cnt_w(SLOTS);
  localparam int unsigned LAST  = SLOTS - 1;

  logic [PH_W-1:0]  ph_q;
  logic             seq_wrap;
  logic [NIB_W-1:0] slice [SLOTS];

  assign seq_wrap = (ph_q == PH_W'(LAST));

  for (genvar g = 0; g < SLOTS; g++) begin : g_slice
    assign slice[g] = act_pair[rxmux_pkg::slot_lsb(g, SLOTS, NIB_W) +: NIB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      act_pair <= '0;
      nib_out  <= '0;
      nib_sof  <= 1'b0;
    end else begin
      nib_out <= slice[ph_q];
      nib_sof <= (ph_q == '0);
      if (seq_wrap) begin
        act_pair <= pair_next;
        ph_q     <= '0;
      end else begin
        ph_q     <= ph_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxmux_if_port.sv
module rxmux_if_port #(
  parameter int unsigned W   = rxmux_pkg::DEF_IF_W,
  parameter int unsigned DIV = rxmux_pkg::DEF_IF_DIV
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb,
  input  logic [W-1:0]   samp,
  output logic [W-1:0]   if_out,
  output logic           if_dv
);

  localparam int unsigned CW = rxmux_pkg::cnt_w(DIV);

  logic [CW-1:0] div_q;
  logic          upd;
  logic [W-1:0]  hold_q;
  logic [W-1:0]  fresh;

  assign upd   = (div_q == CW'(DIV - 1));
  assign fresh = stb ? samp : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      hold_q <= '0;
      if_out <= '0;
      if_dv  <= 1'b0;
    end else begin
      hold_q <= fresh;
      if_dv  <= upd;
      div_q  <= upd ? '0 : div_q + 1'b1;
      if (upd) if_out <= fresh;
    end
  end

endmodule

// File: rtl/rxconv_out_mux.sv
module rxconv_out_mux #(
  parameter int unsigned SAMP_W = rxmux_pkg::DEF_SAMP_W,
  parameter int unsigned NIB_W  = rxmux_pkg::DEF_NIB_W,
  parameter int unsigned IF_W   = rxmux_pkg::DEF_IF_W,
  parameter int unsigned IF_DIV = rxmux_pkg::DEF_IF_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iq_stb,
  input  logic [SAMP_W-1:0] i_samp,
  input  logic [SAMP_W-1:0] q_samp,
  input  logic              if_stb,
  input  logic [IF_W-1:0]   if_samp,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_sof,
  output logic [IF_W-1:0]   if_out,
  output logic              if_dv
);

  localparam int unsigned SLOTS  = 2 * (SAMP_W / NIB_W);
  localparam int unsigned PAIR_W = 2 * SAMP_W;

  // named internal events, observed by the bound checker
  logic [PAIR_W-1:0] pair_next;
  logic [PAIR_W-1:0] act_pair;

  rxmux_pair_stage #(.SAMP_W(SAMP_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (iq_stb),
    .i_in      (i_samp),
    .q_in      (q_samp),
    .pair_next (pair_next)
  );

  rxmux_nib_seq #(.SAMP_W(SAMP_W), .NIB_W(NIB_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_next (pair_next),
    .nib_out   (nib_out),
    .nib_sof   (nib_sof),
    .act_pair  (act_pair)
  );

  rxmux_if_port #(.W(IF_W), .DIV(IF_DIV)) u_if (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (if_stb),
    .samp   (if_samp),
    .if_out (if_out),
    .if_dv  (if_dv)
  );

endmodule

// File: rtl/rxconv_out_mux_chk.sv
module rxconv_out_mux_chk #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned DIV    = 2,
  parameter int unsigned PAIR_W = 16,
  parameter int unsigned IF_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nib_sof,
  input logic [PAIR_W-1:0] act_pair,
  input logic              if_stb,
  input logic [IF_W-1:0]   if_samp,
  input logic [IF_W-1:0]   if_out,
  input logic              if_dv
);

  logic        armed;
  int unsigned fgap;
  int unsigned igap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      fgap  <= SLOTS - 2;
      igap  <= DIV - 1;
    end else begin
      armed <= 1'b1;
      fgap  <= nib_sof ? 0 : ((fgap == SLOTS - 1) ? 0 : fgap + 1);
      igap  <= if_dv   ? 0 : ((igap == DIV - 1)   ? 0 : igap + 1);
    end
  end

  // R3
  frame_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (nib_sof == (fgap == SLOTS - 1)));

  // R4
  pair_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$stable(act_pair)) |=> nib_sof);

  // R8
  if_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (if_dv == (igap == DIV - 1)));

  // R9
  if_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && if_stb && (igap == DIV - 2)) |=> (if_dv && (if_out == $past(if_samp))));

  // R10
  if_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$stable(if_out)) |-> if_dv);

endmodule

bind rxconv_out_mux rxconv_out_mux_chk #(
  .SLOTS(SLOTS), .DIV(IF_DIV), .PAIR_W(PAIR_W), .IF_W(IF_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nib_sof  (nib_sof),
  .act_pair (act_pair),
  .if_stb   (if_stb),
  .if_samp  (if_samp),
  .if_out   (if_out),
  .if_dv    (if_dv)
);

// File: tb/rxconv_out_mux_tb.sv
`timescale 1ns/1ps
module rxconv_out_mux_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iq_stb = 1'b0;
  logic [7:0]  i_samp = '0;
  logic [7:0]  q_samp = '0;
  logic        if_stb = 1'b0;
  logic [11:0] if_samp = '0;
  logic [3:0]  nib_out;
  logic        nib_sof;
  logic [11:0] if_out;
  logic        if_dv;

  always #2 clk = ~clk;

  rxconv_out_mux u_dut (
    .clk(clk), .rst_n(rst_n), .iq_stb(iq_stb), .i_samp(i_samp), .q_samp(q_samp),
    .if_stb(if_stb), .if_samp(if_samp), .nib_out(nib_out), .nib_sof(nib_sof),
    .if_out(if_out), .if_dv(if_dv)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_ph = 0;
  int m_ai = 0, m_aq = 0;
  int strobes[$];
  int m_ic = 0;
  int m_ih = 0;
  int e_nib = 0, e_sof = 0, e_if = 0, e_dv = 0;
  string ntag = "R2";
  string itag = "R9";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_zero(input string what);
    chk(nib_out == 0, "R1", {what, " nib_out"}, int'(nib_out), 0);
    chk(nib_sof == 0, "R1", {what, " nib_sof"}, int'(nib_sof), 0);
    chk(if_out == 0,  "R1", {what, " if_out"},  int'(if_out), 0);
    chk(if_dv == 0,   "R1", {what, " if_dv"},   int'(if_dv), 0);
  endtask

  // apply inputs at a falling edge, advance the model over the next rising
  // edge, then compare at the following falling edge
  task automatic step(input bit iqv, input int ii, input int qq,
                      input bit ifv, input int ifs);
    iq_stb = iqv; i_samp = 8'(ii); q_samp = 8'(qq);
    if_stb = ifv; if_samp = 12'(ifs);
    case (m_ph)
      0: e_nib = (m_ai >> 4) & 15;
      1: e_nib = m_ai & 15;
      2: e_nib = (m_aq >> 4) & 15;
      default: e_nib = m_aq & 15;
    endcase
    e_sof = (m_ph == 0);
    if (iqv) strobes.push_back(((ii & 255) << 8) | (qq & 255));
    if (m_ph == 3) begin
      if (strobes.size() > 0) begin
        m_ai = (strobes[$] >> 8) & 255;
        m_aq = strobes[$] & 255;
      end
      strobes.delete();
    end
    m_ph = (m_ph + 1) % 4;
    if (m_ic == 1) begin
      e_if = ifv ? (ifs & 12'hfff) : m_ih;
      e_dv = 1;
    end else begin
      e_dv = 0;
    end
    if (ifv) m_ih = ifs & 12'hfff;
    m_ic = (m_ic + 1) % 2;
    @(negedge clk);
    chk(int'(nib_out) == e_nib, ntag, "nib_out", int'(nib_out), e_nib);
    chk(int'(nib_sof) == e_sof, "R3", "nib_sof", int'(nib_sof), e_sof);
    chk(int'(if_out) == e_if, itag, "if_out", int'(if_out), e_if);
    chk(int'(if_dv) == e_dv, "R8", "if_dv", int'(if_dv), e_dv);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  task automatic to_phase(input int p);
    while (m_ph != p) step(0, 0, 0, 0, 0);
  endtask

  logic [15:0] lf = 16'hace1;

  initial begin
    @(negedge clk);
    chk_zero("in reset");
    @(negedge clk);
    chk_zero("in reset");
    rst_n = 1'b1;
    chk_zero("after release");

    // R7: before any strobe the repeated pair is zero; R8 cadence from start
    ntag = "R7"; itag = "R10";
    idle(4);

    // R2: a known pair, then its repeats (R7)
    ntag = "R2"; itag = "R9";
    step(1, 8'ha5, 8'h3c, 1, 12'h9b1);
    idle(7);
    ntag = "R7"; itag = "R10";
    idle(8);

    // R4: strobe in the middle of a sequence
    ntag = "R4";
    to_phase(1);
    step(1, 8'h17, 8'he2, 0, 0);
    idle(7);

    // R5: strobe on the edge that drives the Q low nibble
    ntag = "R5";
    to_phase(3);
    step(1, 8'hc4, 8'h5f, 0, 0);
    idle(4);

    // R6: two strobes inside one sequence, last one wins
    ntag = "R6";
    to_phase(0);
    step(1, 8'h11, 8'h22, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 8'h9e, 8'h6d, 0, 0);
    idle(5);

    // R9 / R10: IF strobe on a non-update edge, then on an update edge
    itag = "R10";
    while (m_ic != 0) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 12'h3a7);
    itag = "R9";
    step(0, 0, 0, 1, 12'h5c2);
    idle(2);
    itag = "R10";
    idle(4);

    // coincident: pair load and IF update on the same edge
    ntag = "R5"; itag = "R9";
    to_phase(3);
    step(1, 8'h6b, 8'hd8, 1, 12'he41);
    idle(4);

    // mixed traffic
    ntag = "R2"; itag = "R9";
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[3], int'(lf[15:8]), int'(lf[7:0] ^ lf[15:8]),
           lf[5], int'({lf[11:0]}));
    end
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule